// File: doc/BRIEF.md
# Dual-Lane Q15 Rounding Multiplier

This block takes two 32-bit words, each packing two signed Q1.15 fractions, and multiplies them lane by lane. The upper halfwords are multiplied together and the lower halfwords are multiplied together. Each lane product is doubled to Q1.31, rounded to nearest by adding half of an output LSB, and cut back to its upper sixteen bits. The two lane results are packed into one 32-bit result word.

Only one input pair overflows a lane: minus one times minus one. In that case the lane result is clamped to the largest positive fraction. The event is also recorded in a sticky overflow bit, bit 21 of a 32-bit status word. Software can load and read that word. Loading zero clears the flag, and after that a read shows the bit set only if a later operation saturated a lane.

Operands enter through a valid/ready handshake. They pass through two register stages, products first and then rounded results, so the latency is fixed at two cycles when the output is not stalled. Backpressure from the output stalls the pipeline without losing data.

Top module: `q15_pair_mul`

## Requirements
- R1: Lane 1 of the result (bits 31:16) depends only on bits 31:16 of both operands. Lane 0 (bits 15:0) depends only on bits 15:0 of both operands.
- R2: Each lane value is read as a signed two's-complement 16-bit number. The lane result is bits 31:16 of (2·a·b + 0x00008000), computed in 32 bits.
- R3: When both inputs of a lane are 0x8000, that lane returns 0x7FFF. The other lane is computed normally.
- R4: An operation with at least one saturating lane sets status bit 21. The bit is visible in the same cycle that the operation's result is first presented on the output.
- R5: The overflow bit is sticky. Operations without saturation never clear it.
- R6: A status write loads all 32 bits from the write data. This means writing zero clears bit 21. If a saturating operation enters the output stage in the same cycle as a write, bit 21 ends up set. Without a write, the status bits other than 21 do not change.
- R7: With out_ready held high, an operand pair accepted at a clock edge appears on out_data with out_valid high after the second following edge.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_data stays unchanged. Results leave in acceptance order, with none lost or repeated.
- R9: in_ready is low only while out_valid is high and out_ready is low.
- R10: After reset, out_valid is low, in_ready is high and the status word reads zero.
- R11: A presented lane result is never 0x8000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block can take an operand pair |
| op_a | input | 32 | First packed operand, two Q1.15 lanes |
| op_b | input | 32 | Second packed operand, two Q1.15 lanes |
| out_valid | output | 1 | Result word present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 32 | Packed rounded lane results |
| stat_wr | input | 1 | Load the status word |
| stat_wdata | input | 32 | Value to load into the status word |
| stat_rdata | output | 32 | Status word, overflow flag at bit 21 |

## Verification
The assertions check the following on every cycle:
- output holding under backpressure and the link between in_ready and an output stall;
- that the flag is set whenever a saturating operation moves to the output stage, and that it is sticky;
- the clear and load behaviour of status writes, and that no lane ever shows 0x8000.

The arithmetic itself can only be shown by the bench's scenarios. These include:
- signed rounding across all sign combinations and the four corner values per lane;
- lane independence;
- the directed pair whose result is 0x7FFD098C;
- the exact two-cycle latency and in-order delivery under random output stalls.

// File: rtl/q15_pkg.sv
package q15_pkg;

    // Default geometry of the packed operand
    localparam int LANE_W_DEF   = 16;
    localparam int LANES_DEF    = 2;
    // Position of the sticky overflow flag inside the status word
    localparam int FLAG_BIT_DEF = 21;

    // Reduction used to fold per-lane saturation events into one flag update
    function automatic logic any_lane(input logic [LANES_DEF-1:0] v);
        return |v;
    endfunction

endpackage

// File: rtl/q15_lane_mul.sv
// Stage-one arithmetic for one lane: signed product and overflow detection
module q15_lane_mul #(
    parameter int W = 16,
    localparam int PW = 2 * W
) (
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    output logic [PW-1:0] prod,
    output logic          sat
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

    always_comb begin
        prod = PW'($signed(a) * $signed(b));
        sat  = (a == MOST_NEG) && (b == MOST_NEG);
    end
endmodule

// File: rtl/q15_lane_rnd.sv
// Stage-two arithmetic for one lane: double, round half up, keep upper half
module q15_lane_rnd #(
    parameter int W = 16,
    localparam int PW = 2 * W
) (
    input  logic [PW-1:0] prod,
    input  logic          sat,
    output logic [W-1:0]  res
);
    localparam logic [PW-1:0] HALF_LSB = PW'(1) << (W - 1);
    localparam logic [W-1:0]  MOST_POS = {1'b0, {(W-1){1'b1}}};

    always_comb begin
        if (sat) begin
            res = MOST_POS;
        end else begin
            res = W'(((prod << 1) + HALF_LSB) >> W);
        end
    end
endmodule

// File: rtl/q15_stat_reg.sv
// Status word with a sticky overflow bit
module q15_stat_reg #(
    parameter int DW       = 32,
    parameter int FLAG_BIT = 21
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          set,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] st_d, st_q;

    always_comb begin
        st_d = wr ? wdata : st_q;
        if (set) begin
            st_d[FLAG_BIT] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q;
endmodule

// File: rtl/q15_pair_mul.sv
module q15_pair_mul
    import q15_pkg::*;
#(
    parameter int LANE_W   = LANE_W_DEF,
    parameter int LANES    = LANES_DEF,
    parameter int FLAG_BIT = FLAG_BIT_DEF,
    localparam int DW      = LANE_W * LANES,
    localparam int PW      = 2 * LANE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data,
    input  logic          stat_wr,
    input  logic [DW-1:0] stat_wdata,
    output logic [DW-1:0] stat_rdata
);

    typedef struct packed {
        logic                      s1_v;
        logic [LANES-1:0][PW-1:0]  s1_prod;
        logic [LANES-1:0]          s1_sat;
        logic                      s2_v;
        logic [DW-1:0]             s2_data;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic [LANES-1:0][PW-1:0] mul_prod;
    logic [LANES-1:0]         mul_sat;
    logic [DW-1:0]            rnd_word;
    logic                     s2_free;
    logic                     s1_adv;
    logic                     accept;
    logic                     ovf_set;

    // Per-lane datapath: multiply on the inputs, round on the stage-one register
    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        q15_lane_mul #(.W(LANE_W)) u_mul (
            .a    (op_a[ln*LANE_W +: LANE_W]),
            .b    (op_b[ln*LANE_W +: LANE_W]),
            .prod (mul_prod[ln]),
            .sat  (mul_sat[ln])
        );

        q15_lane_rnd #(.W(LANE_W)) u_rnd (
            .prod (pipe_q.s1_prod[ln]),
            .sat  (pipe_q.s1_sat[ln]),
            .res  (rnd_word[ln*LANE_W +: LANE_W])
        );
    end

    always_comb begin
        s2_free  = !pipe_q.s2_v || out_ready;
        s1_adv   = pipe_q.s1_v && s2_free;
        in_ready = !pipe_q.s1_v || s2_free;
        accept   = in_valid && in_ready;

        pipe_d = pipe_q;

        // Output stage refills whenever it is empty or being drained
        if (s2_free) begin
            pipe_d.s2_v = pipe_q.s1_v;
            if (pipe_q.s1_v) begin
                pipe_d.s2_data = rnd_word;
            end
        end

        // Product stage is free whenever its content moves on
        if (in_ready) begin
            pipe_d.s1_v = in_valid;
            if (accept) begin
                pipe_d.s1_prod = mul_prod;
                pipe_d.s1_sat  = mul_sat;
            end
        end

        ovf_set = s1_adv && (|pipe_q.s1_sat);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    q15_stat_reg #(.DW(DW), .FLAG_BIT(FLAG_BIT)) u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (stat_wr),
        .wdata (stat_wdata),
        .set   (ovf_set),
        .rdata (stat_rdata)
    );

    assign out_valid = pipe_q.s2_v;
    assign out_data  = pipe_q.s2_data;

endmodule

// File: rtl/q15_pair_mul_chk.sv
module q15_pair_mul_chk #(
    parameter int LANE_W   = 16,
    parameter int LANES    = 2,
    parameter int FLAG_BIT = 21,
    localparam int DW      = LANE_W * LANES
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic [DW-1:0] out_data,
    input logic          stat_wr,
    input logic [DW-1:0] stat_wdata,
    input logic [DW-1:0] stat_rdata,
    input logic          ovf_set
);
    localparam logic [DW-1:0]     OTHER_MASK = ~(DW'(1) << FLAG_BIT);
    localparam logic [LANE_W-1:0] MOST_NEG   = {1'b1, {(LANE_W-1){1'b0}}};

    AST_HOLD_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8

    AST_READY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> (out_valid && !out_ready)); // R9

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_set |=> stat_rdata[FLAG_BIT]); // R4

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rdata[FLAG_BIT] && !stat_wr) |=> stat_rdata[FLAG_BIT]); // R5

    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !stat_wdata[FLAG_BIT] && !ovf_set) |=> !stat_rdata[FLAG_BIT]); // R6

    AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> (((stat_rdata ^ $past(stat_wdata)) & OTHER_MASK) == '0)); // R6

    AST_OTHER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_wr |=> $stable(stat_rdata & OTHER_MASK)); // R6

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane_chk
        AST_NO_MOST_NEG: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (out_data[ln*LANE_W +: LANE_W] != MOST_NEG)); // R11
    end
endmodule

bind q15_pair_mul q15_pair_mul_chk #(
    .LANE_W   (LANE_W),
    .LANES    (LANES),
    .FLAG_BIT (FLAG_BIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .stat_wr    (stat_wr),
    .stat_wdata (stat_wdata),
    .stat_rdata (stat_rdata),
    .ovf_set    (ovf_set)
);

// File: tb/q15_pair_mul_test.sv
`timescale 1ns/1ps
module q15_pair_mul_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;
    logic        stat_wr = 1'b0;
    logic [31:0] stat_wdata = '0;
    logic [31:0] stat_rdata;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [31:0] qa [256];
    logic [31:0] qb [256];
    logic [31:0] exp_q [$];
    bit          flag_exp = 1'b0;

    always #2 clk = ~clk;

    q15_pair_mul uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .op_a       (op_a),
        .op_b       (op_b),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_data   (out_data),
        .stat_wr    (stat_wr),
        .stat_wdata (stat_wdata),
        .stat_rdata (stat_rdata)
    );

    // Reference lane from R2/R3
    function automatic logic [15:0] ref_lane(input logic [15:0] a, input logic [15:0] b);
        int          p;
        logic [31:0] t;
        if (a == 16'h8000 && b == 16'h8000) return 16'h7FFF;
        p = int'($signed(a)) * int'($signed(b));
        p = p * 2 + 32'sh8000;
        t = p;
        return t[31:16];
    endfunction

    function automatic logic [31:0] ref_word(input logic [31:0] a, input logic [31:0] b);
        return {ref_lane(a[31:16], b[31:16]), ref_lane(a[15:0], b[15:0])};
    endfunction

    function automatic bit ref_sat(input logic [31:0] a, input logic [31:0] b);
        return (a[31:16] == 16'h8000 && b[31:16] == 16'h8000) ||
               (a[15:0] == 16'h8000 && b[15:0] == 16'h8000);
    endfunction

    function automatic logic [15:0] pick16();
        logic [15:0] c [4];
        c = '{16'h8000, 16'h7FFF, 16'h0000, 16'hFFFF};
        if (($urandom % 6) == 0) return c[$urandom % 4];
        return 16'($urandom);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Streams n operand pairs; bp enables random output stalls
    task automatic run_batch(input int n, input bit bp);
        int          sent = 0;
        int          guard = 0;
        bit          prev_stall = 1'b0;
        logic [31:0] prev_data = '0;
        logic [31:0] e;
        while ((sent < n || exp_q.size() != 0) && guard < 20000) begin
            @(negedge clk);
            guard++;
            in_valid  = (sent < n) && (!bp || ($urandom % 4 != 0));
            op_a      = qa[sent % 256];
            op_b      = qb[sent % 256];
            out_ready = !bp || ($urandom % 3 != 0);
            #1;
            if (prev_stall) begin
                check(out_valid && out_data == prev_data, "R8 hold", out_data, prev_data);
            end
            if (!in_ready) begin
                check(out_valid && !out_ready, "R9 ready", {31'b0, in_ready}, 32'd1);
            end
            if (in_valid && in_ready) begin
                exp_q.push_back(ref_word(op_a, op_b));
                flag_exp = flag_exp | ref_sat(op_a, op_b);
                sent++;
            end
            if (out_valid && out_ready) begin
                e = exp_q.pop_front();
                check(out_data == e, "R1 R2 R3 lane result", out_data, e);
            end
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
        end
        @(negedge clk);
        in_valid  = 1'b0;
        out_ready = 1'b1;
        check(guard < 20000, "R8 drain", 32'(exp_q.size()), 32'd0);
    endtask

    task automatic single(input logic [31:0] a, input logic [31:0] b);
        qa[0] = a;
        qb[0] = b;
        run_batch(1, 1'b0);
    endtask

    task automatic write_stat(input logic [31:0] v);
        @(negedge clk);
        stat_wr    = 1'b1;
        stat_wdata = v;
        @(negedge clk);
        stat_wr    = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] corner [4];
        int          dummy;
        corner = '{16'h8000, 16'h7FFF, 16'h0000, 16'hFFFF};
        dummy  = $urandom(32'd2024);

        // R10: reset state
        repeat (3) @(negedge clk);
        check(!out_valid, "R10 out_valid", {31'b0, out_valid}, 32'd0);
        check(in_ready, "R10 in_ready", {31'b0, in_ready}, 32'd1);
        check(stat_rdata == 32'd0, "R10 status", stat_rdata, 32'd0);
        rst_n = 1'b1;

        // R7: latency of two edges, directed pair from R2
        @(negedge clk);
        out_ready = 1'b1;
        in_valid  = 1'b1;
        op_a      = 32'h80011234;
        op_b      = 32'h80024321;
        @(negedge clk);
        in_valid  = 1'b0;
        check(!out_valid, "R7 one edge", {31'b0, out_valid}, 32'd0);
        @(negedge clk);
        check(out_valid, "R7 two edges", {31'b0, out_valid}, 32'd1);
        check(out_data == 32'h7FFD098C, "R2 directed pair", out_data, 32'h7FFD098C);
        check(stat_rdata[21] == 1'b0, "R4 no overflow", stat_rdata, 32'd0);
        @(negedge clk);

        // R1: lane independence, hi lane large, lo lane small and negative
        single(32'h40000003, 32'h4000FFFF);
        check(flag_exp == 1'b0, "R1 no sat expected", {31'b0, flag_exp}, 32'd0);

        // R3 corner sweep over all value pairs in both lanes
        for (int i = 0; i < 4; i++) begin
            for (int j = 0; j < 4; j++) begin
                qa[i*4+j] = {corner[i], corner[j]};
                qb[i*4+j] = {corner[j], corner[i]};
            end
        end
        run_batch(16, 1'b0);
        check(stat_rdata[21] == 1'b1, "R4 set by corner", stat_rdata, 32'h00200000);

        // R6: writing zero clears
        write_stat(32'h0);
        flag_exp = 1'b0;
        check(stat_rdata == 32'h0, "R6 clear", stat_rdata, 32'h0);

        // R5: non-saturating op keeps clear flag clear
        single(32'h7FFF7FFF, 32'h7FFF8001);
        check(stat_rdata[21] == 1'b0, "R5 no spurious set", stat_rdata, 32'h0);

        // R3/R4: single-lane saturation, other lane normal
        single(32'h80004000, 32'h80004000);
        check(stat_rdata[21] == 1'b1, "R4 set lane1", stat_rdata, 32'h00200000);

        // R5: later non-saturating op leaves flag set
        single(32'h12345678, 32'h0FED0001);
        check(stat_rdata[21] == 1'b1, "R5 sticky", stat_rdata, 32'h00200000);

        // R3: both lanes saturate in one op
        write_stat(32'h0);
        single(32'h80008000, 32'h80008000);
        check(stat_rdata == 32'h00200000, "R3 both lanes flag", stat_rdata, 32'h00200000);

        // R6: full word load and read back
        write_stat(32'hA5A50000);
        check(stat_rdata == 32'hA5A50000, "R6 load", stat_rdata, 32'hA5A50000);
        write_stat(32'h0);
        check(stat_rdata == 32'h0, "R6 clear again", stat_rdata, 32'h0);

        // R8: random stream under backpressure
        flag_exp = 1'b0;
        for (int k = 0; k < 200; k++) begin
            qa[k] = {pick16(), pick16()};
            qb[k] = {pick16(), pick16()};
        end
        run_batch(200, 1'b1);
        check(stat_rdata[21] == flag_exp, "R4 R5 random flag", stat_rdata, {10'b0, flag_exp, 21'b0});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule